// File: doc/BRIEF.md
# Operand Address Resolver

This unit sits between instruction decode and operand fetch. One request carries the decoded operand fields of an instruction: an operand kind, a complex field, a variable field and an immediate constant. The unit answers with either the immediate value or the final data-memory address of the operand. To reach an element of an array-like complex, it may need to read the element index from data memory. For a dynamic complex, it first reads the stored base pointer, which adds one level of indirection.

Two complex flavours are handled. A logical complex holds four-byte elements, so its index is scaled by four. A symbol complex holds byte elements, so its index is used unscaled. All address arithmetic wraps modulo 2^ADDR_W.

Requests enter through a valid/ready port. `req_ready` is high only while the unit is idle, and a request is taken on a clock edge where both `req_valid` and `req_ready` are high. Results leave through a valid/ready port. While `rsp_valid` is high and `rsp_ready` is low, the response holds still and no new request is taken. Data memory is read through a plain read port with a fixed one-cycle latency: `mem_rd_data` is valid in the cycle after a cycle with `mem_rd_en` high.

Top module: `operand_addr_resolver`

## Requirements
- R1: With `req_kind` = 0 (constant), the response carries `rsp_imm`=1, `rsp_value`=`req_const` and `rsp_addr`=0. It is valid one cycle after acceptance, with no memory read.
- R2: With `req_kind` = 1 (variable), or with the reserved code 3, the response carries `rsp_addr`=`req_var` and `rsp_imm`=0. It is valid one cycle after acceptance, with no memory read.
- R3: With `req_kind` = 2 (complex), `req_dyn`=0 and `req_var`=0, the operand is the whole complex. `rsp_addr`=`req_cplx`, valid one cycle after acceptance, with no memory read.
- R4: With `req_kind` = 2, `req_var`≠0 and `req_sym`=0 (logical), the address is base + 4·M[`req_var`] mod 2^ADDR_W.
- R5: With `req_kind` = 2, `req_var`≠0 and `req_sym`=1 (symbol), the address is base + M[`req_var`] mod 2^ADDR_W.
- R6: With `req_kind` = 2 and `req_dyn`=1, the base is M[`req_cplx`]. That word is read before any index read. A dynamic whole complex (`req_var`=0) answers with that base as its address.
- R7: A static element answers 3 cycles after acceptance using one read. A dynamic whole complex answers 3 cycles after acceptance using one read. A dynamic element answers 5 cycles after acceptance using two reads.
- R8: While `rsp_valid`=1 and `rsp_ready`=0, the response fields hold stable and `req_ready` stays low.
- R9: `mem_rd_en` is never high for two cycles in a row, and never high while `rsp_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_kind | input | 2 | 0 constant, 1 variable, 2 complex, 3 treated as variable |
| req_sym | input | 1 | 1 symbol complex (scale 1), 0 logical complex (scale 4) |
| req_dyn | input | 1 | Complex field points at the word holding the base |
| req_cplx | input | ADDR_W | Complex field |
| req_var | input | ADDR_W | Variable field (index variable address, or 0) |
| req_const | input | DATA_W | Immediate constant |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer accepts response |
| rsp_imm | output | 1 | Response is an immediate value |
| rsp_addr | output | ADDR_W | Resolved operand address |
| rsp_value | output | DATA_W | Immediate value (0 when not immediate) |
| mem_rd_en | output | 1 | Data memory read strobe |
| mem_rd_addr | output | ADDR_W | Data memory read address |
| mem_rd_data | input | DATA_W | Read data, valid one cycle after the strobe |

## Verification
A wrong sequencer state shows up at the ports as a response that arrives one or more cycles early or late. It can also show up as an extra or missing read strobe, or as a read address taken from the wrong field. All of these are visible within five cycles of acceptance. A wrong scale or a lost indirection gives an address that differs from the value computed in the bench on the first response of that kind. The sweep covers every kind, flavour and indirection combination, with bases and indices chosen so that the address sums wrap.

// File: rtl/aru_pkg.sv
package aru_pkg;
  typedef enum logic [1:0] {
    OPK_CONST = 2'd0,
    OPK_VAR   = 2'd1,
    OPK_CPLX  = 2'd2,
    OPK_RSVD  = 2'd3
  } opkind_e;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_READ_PTR = 2'd1,
    ST_READ_IDX = 2'd2,
    ST_DONE     = 2'd3
  } aru_state_e;
endpackage

// File: rtl/aru_elem_addr.sv
module aru_elem_addr #(
  parameter int ADDR_W    = 16,
  parameter int LOG_SHIFT = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] index,
  input  logic              sym,
  output logic [ADDR_W-1:0] elem
);
  logic [ADDR_W-1:0] scaled;

  generate
    if (LOG_SHIFT == 0) begin : g_noscale
      assign scaled = index;
    end else begin : g_scale
      assign scaled = sym ? index : {index[ADDR_W-1-LOG_SHIFT:0], {LOG_SHIFT{1'b0}}};
    end
  endgenerate

  assign elem = base + scaled;
endmodule

// File: rtl/aru_seq.sv
module aru_seq
  import aru_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic              req_sym,
  input  logic              req_dyn,
  input  logic [ADDR_W-1:0] req_cplx,
  input  logic [ADDR_W-1:0] req_var,
  input  logic [DATA_W-1:0] req_const,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_imm,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [DATA_W-1:0] rsp_value,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic [ADDR_W-1:0] base_o,
  output logic              sym_o,
  input  logic [ADDR_W-1:0] elem_addr
);
  aru_state_e        state;
  logic              waiting;
  logic              elem_q;
  logic              sym_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] var_q;
  logic [ADDR_W-1:0] rd_word;

  assign rd_word     = mem_rd_data[ADDR_W-1:0];
  assign req_ready   = (state == ST_IDLE);
  assign rsp_valid   = (state == ST_DONE);
  assign mem_rd_en   = ((state == ST_READ_PTR) || (state == ST_READ_IDX)) && !waiting;
  assign mem_rd_addr = (state == ST_READ_PTR) ? base_q : var_q;
  assign base_o      = base_q;
  assign sym_o       = sym_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      waiting   <= 1'b0;
      elem_q    <= 1'b0;
      sym_q     <= 1'b0;
      base_q    <= '0;
      var_q     <= '0;
      rsp_imm   <= 1'b0;
      rsp_addr  <= '0;
      rsp_value <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            sym_q     <= req_sym;
            var_q     <= req_var;
            base_q    <= req_cplx;
            elem_q    <= (req_var != '0);
            waiting   <= 1'b0;
            rsp_imm   <= 1'b0;
            rsp_value <= '0;
            case (opkind_e'(req_kind))
              OPK_CONST: begin
                rsp_imm   <= 1'b1;
                rsp_value <= req_const;
                rsp_addr  <= '0;
                state     <= ST_DONE;
              end
              OPK_CPLX: begin
                if (req_dyn)                state <= ST_READ_PTR;
                else if (req_var != '0)     state <= ST_READ_IDX;
                else begin
                  rsp_addr <= req_cplx;
                  state    <= ST_DONE;
                end
              end
              default: begin
                rsp_addr <= req_var;
                state    <= ST_DONE;
              end
            endcase
          end
        end
        ST_READ_PTR: begin
          if (!waiting) begin
            waiting <= 1'b1;
          end else begin
            waiting <= 1'b0;
            base_q  <= rd_word;
            if (elem_q) begin
              state <= ST_READ_IDX;
            end else begin
              rsp_addr <= rd_word;
              state    <= ST_DONE;
            end
          end
        end
        ST_READ_IDX: begin
          if (!waiting) begin
            waiting <= 1'b1;
          end else begin
            waiting  <= 1'b0;
            rsp_addr <= elem_addr;
            state    <= ST_DONE;
          end
        end
        default: begin
          if (rsp_ready) state <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/operand_addr_resolver.sv
module operand_addr_resolver #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic              req_sym,
  input  logic              req_dyn,
  input  logic [ADDR_W-1:0] req_cplx,
  input  logic [ADDR_W-1:0] req_var,
  input  logic [DATA_W-1:0] req_const,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_imm,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [DATA_W-1:0] rsp_value,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data
);
  localparam int LOG_SHIFT = 2;

  logic [ADDR_W-1:0] base_w;
  logic              sym_w;
  logic [ADDR_W-1:0] elem_w;

  aru_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_kind    (req_kind),
    .req_sym     (req_sym),
    .req_dyn     (req_dyn),
    .req_cplx    (req_cplx),
    .req_var     (req_var),
    .req_const   (req_const),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_imm     (rsp_imm),
    .rsp_addr    (rsp_addr),
    .rsp_value   (rsp_value),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .mem_rd_data (mem_rd_data),
    .base_o      (base_w),
    .sym_o       (sym_w),
    .elem_addr   (elem_w)
  );

  aru_elem_addr #(.ADDR_W(ADDR_W), .LOG_SHIFT(LOG_SHIFT)) u_elem (
    .base  (base_w),
    .index (mem_rd_data[ADDR_W-1:0]),
    .sym   (sym_w),
    .elem  (elem_w)
  );
endmodule

// File: rtl/aru_checker.sv
module aru_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_kind,
  input logic [ADDR_W-1:0] req_var,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_imm,
  input logic [ADDR_W-1:0] rsp_addr,
  input logic [DATA_W-1:0] rsp_value,
  input logic              mem_rd_en
);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_imm) && $stable(rsp_value)));

  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  p_rd_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

  p_no_rd_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !mem_rd_en);

  p_imm_zero_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_imm) |-> (rsp_addr == '0));

  p_var_direct_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_kind == 2'd1) |=> (rsp_valid && !rsp_imm && rsp_addr == $past(req_var)));
endmodule

bind operand_addr_resolver aru_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_kind  (req_kind),
  .req_var   (req_var),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_imm   (rsp_imm),
  .rsp_addr  (rsp_addr),
  .rsp_value (rsp_value),
  .mem_rd_en (mem_rd_en)
);

// File: tb/sim_operand_addr_resolver.sv
`timescale 1ns/1ps
module sim_operand_addr_resolver;
  localparam int AW = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_kind = 2'd0;
  logic          req_sym = 1'b0;
  logic          req_dyn = 1'b0;
  logic [AW-1:0] req_cplx = '0;
  logic [AW-1:0] req_var = '0;
  logic [DW-1:0] req_const = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic          rsp_imm;
  logic [AW-1:0] rsp_addr;
  logic [DW-1:0] rsp_value;
  logic          mem_rd_en;
  logic [AW-1:0] mem_rd_addr;
  logic [DW-1:0] mem_rd_data = '0;

  int total = 0;
  int bad = 0;
  int nrd = 0;
  logic [AW-1:0] rd_log [0:3];

  always #4 clk = ~clk;

  function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
    return a * 16'd40503 + 16'd7;
  endfunction

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rd_data <= memf(mem_rd_addr);
      if (nrd < 4) rd_log[nrd] <= mem_rd_addr;
      nrd <= nrd + 1;
    end
  end

  operand_addr_resolver #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_sym(req_sym), .req_dyn(req_dyn), .req_cplx(req_cplx),
    .req_var(req_var), .req_const(req_const), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_imm(rsp_imm), .rsp_addr(rsp_addr), .rsp_value(rsp_value), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] kind, input logic sym, input logic dyn,
                     input logic [AW-1:0] cplx, input logic [AW-1:0] vr,
                     input logic [DW-1:0] cst, input int hold);
    int n;
    int exp_lat;
    int exp_rd;
    logic [AW-1:0] base;
    logic [AW-1:0] idx;
    logic [AW-1:0] exp_addr;
    logic          exp_imm;
    logic [AW-1:0] a0;
    req_kind = kind; req_sym = sym; req_dyn = dyn; req_cplx = cplx; req_var = vr; req_const = cst;
    req_valid = 1'b1;
    rsp_ready = (hold == 0);
    nrd = 0;
    @(posedge clk); #1;
    req_valid = 1'b0;
    n = 1;
    while (!rsp_valid && n < 20) begin
      @(posedge clk); #1;
      n++;
    end
    exp_imm = 1'b0;
    base = dyn ? memf(cplx) : cplx;
    idx = memf(vr);
    if (kind == 2'd0) begin
      exp_imm = 1'b1; exp_addr = '0; exp_lat = 1; exp_rd = 0;
    end else if (kind != 2'd2) begin
      exp_addr = vr; exp_lat = 1; exp_rd = 0;
    end else if (vr == '0) begin
      exp_addr = base; exp_lat = dyn ? 3 : 1; exp_rd = dyn ? 1 : 0;
    end else begin
      exp_addr = sym ? AW'(base + idx) : AW'(base + idx * 4);
      exp_lat = dyn ? 5 : 3; exp_rd = dyn ? 2 : 1;
    end
    // R1 R2 R3 R4 R5 R6 : resolved address / immediate
    check(rsp_valid && rsp_addr == exp_addr,
          kind == 2'd0 ? "R1 addr" : kind != 2'd2 ? "R2 addr" : vr == '0 && !dyn ? "R3 addr" :
          dyn ? "R6 addr" : sym ? "R5 addr" : "R4 addr", rsp_addr, exp_addr);
    check(rsp_imm == exp_imm, "R1 imm flag", rsp_imm, exp_imm);
    if (kind == 2'd0) check(rsp_value == cst, "R1 value", rsp_value, cst);
    // R7 latency and read count
    check(n == exp_lat, "R7 latency", n, exp_lat);
    check(nrd == exp_rd, "R7 reads", nrd, exp_rd);
    if (dyn && kind == 2'd2) begin
      a0 = rd_log[0];
      check(a0 == cplx, "R6 pointer read first", a0, cplx);
    end
    if (hold > 0) begin
      for (int h = 0; h < hold; h++) begin
        @(posedge clk); #1;
        check(rsp_valid && rsp_addr == exp_addr && !req_ready, "R8 hold", rsp_addr, exp_addr);
      end
      rsp_ready = 1'b1;
    end
    @(posedge clk); #1;
    check(req_ready && !rsp_valid, "R8 release", req_ready, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_rd_en == 1'b0, "R9 reset state", rsp_valid, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    run(2'd0, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'hBEEF, 0);
    run(2'd0, 1'b1, 1'b1, 16'h1234, 16'h0042, 16'h0001, 0);
    run(2'd1, 1'b0, 1'b0, 16'h0000, 16'h0077, 16'h0000, 0);
    run(2'd3, 1'b0, 1'b0, 16'h0000, 16'hFFFF, 16'h0000, 0);
    for (int d = 0; d < 2; d++)
      for (int s = 0; s < 2; s++)
        for (int c = 0; c < 3; c++)
          for (int v = 0; v < 3; v++) begin
            logic [AW-1:0] cv;
            logic [AW-1:0] vv;
            cv = (c == 0) ? 16'h0010 : (c == 1) ? 16'hFFF0 : 16'h8000;
            vv = (v == 0) ? 16'h0000 : (v == 1) ? 16'h0003 : 16'h7FFF;
            run(2'd2, s[0], d[0], cv, vv, 16'h0000, 0);
          end
    run(2'd2, 1'b0, 1'b1, 16'h0100, 16'h0200, 16'h0000, 3);
    run(2'd0, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h5A5A, 2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule